// File: doc/BRIEF.md
# Serial Command Front-End for a Dual Digital Potentiometer

This block is the serial slave port of a two-channel digital potentiometer controller. It runs on the system clock. It oversamples the serial clock, chip select, serial data and pause pins through two-flop synchronisers and detects the serial clock edges in the system clock domain. Each frame opens with an identification byte. That byte must carry a fixed four-bit device type code together with the value on a four-bit strap address input. An instruction byte follows it. The block decodes the opcode, a two-bit data-register pointer and a pot-select bit from that byte. It then passes the decoded command to the neighbouring register logic as a single-cycle strobe.

Two parameter masks divide the opcodes into three groups. Write-type opcodes wait for one data byte and then strobe. Read-type opcodes raise a read request at once, capture the value that the register logic returns, and shift it out on the serial output. All other opcodes strobe directly after the instruction byte. A pause pin can freeze a frame partway through without losing its place. After reset the port stays inert until chip select has been seen high and then brought low.

Top module: `potcmd_spi_front`

## Requirements
- R1: While reset is asserted and straight after it, miso_oe, cmd_valid and rd_req are all low.
- R2: A frame starts only when chip select goes low after it has been observed high since reset. If chip select is held low through reset, the whole frame is ignored: no strobe and no output enable.
- R3: The first byte of a frame, received MSB first, must hold 4'b0101 in bits 7:4 and the strap_addr value in bits 3:0. On a mismatch the rest of the frame produces no strobe and no output enable until chip select rises.
- R4: The second byte holds the opcode in bits 7:4, the register pointer in bits 3:2, a must-be-zero bit in bit 1 and the pot select in bit 0. If bit 1 is set, the frame is ignored.
- R5: Write-type opcodes (defaults 4'hA and 4'hC) take the next byte MSB first, sampled on rising serial clock edges. They then pulse cmd_valid for exactly one cycle with the opcode, pointer, pot and data.
- R6: Opcodes that are neither read-type nor write-type pulse cmd_valid for one cycle right after the instruction byte, with cmd_data equal to 0. cmd_valid and rd_req are never high together.
- R7: Read-type opcodes (defaults 4'h9 and 4'hB) pulse rd_req for one cycle with cmd_data equal to 0, and rd_data is captured in that cycle. miso_oe rises in the next cycle. The captured byte then appears on miso MSB first, one bit after each falling serial clock edge, over the following eight clocks.
- R8: While chip select is high, miso_oe is low and all frame progress is discarded, so a partly received byte has no effect on the next frame.
- R9: The pause input going low while the serial clock is low freezes the frame, and going high while the clock is low releases it. Clock edges during the pause are neither counted nor shifted. No strobe is issued and miso_oe is low while paused.
- R10: At most one strobe is produced per frame. Bytes after a completed command are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_sck | input | 1 | Serial clock |
| spi_mosi | input | 1 | Serial data in |
| spi_hold_n | input | 1 | Pause input, active low |
| strap_addr | input | 4 | External device address straps |
| rd_data | input | 8 | Register value returned for a read, valid while rd_req is high |
| miso | output | 1 | Serial data out |
| miso_oe | output | 1 | Output enable for miso |
| cmd_valid | output | 1 | One-cycle command strobe |
| rd_req | output | 1 | One-cycle read request |
| cmd_opcode | output | 4 | Decoded opcode |
| cmd_reg | output | 2 | Data-register pointer |
| cmd_pot | output | 1 | Pot select |
| cmd_data | output | 8 | Data byte for write-type commands |

## Verification
A bit counter that has slipped shows up on the first strobe, within the same frame, as a shifted data byte or wrong fields in the decoded command. A pause that fails to freeze the counter shows up the same way. An identity check or arming flag in the wrong state shows up as a strobe in a frame that should have been silent, at most a few system cycles after the last bit. A wrong read state shows up as miso_oe in the wrong level or as a bad bit on miso by the next rising serial clock edge.

// File: rtl/potcmd_pkg.sv
package potcmd_pkg;

    localparam int BYTE_W = 8;
    localparam int TYPE_W = 4;
    localparam int ADDR_W = BYTE_W - TYPE_W;
    localparam int OP_W   = 4;
    localparam int REG_W  = 2;
    localparam int CNT_W  = $clog2(BYTE_W);
    localparam int NUM_OP = 1 << OP_W;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ID,
        ST_INSTR,
        ST_DATA,
        ST_READ,
        ST_DONE
    } frame_st_e;

    typedef struct packed {
        frame_st_e          st;
        logic               seen_high;
        logic               paused;
        logic [CNT_W-1:0]   bitcnt;
        logic [BYTE_W-1:0]  shreg;
        logic [OP_W-1:0]    opcode;
        logic [REG_W-1:0]   regsel;
        logic               pot;
        logic [BYTE_W-1:0]  data;
        logic               cmd_valid;
        logic               rd_req;
    } frame_s;

    typedef struct packed {
        logic               en;
        logic               bit_out;
        logic [BYTE_W-1:0]  shreg;
    } tx_s;

endpackage

// File: rtl/potcmd_sync.sv
module potcmd_sync #(
    parameter int             W       = 1,
    parameter int             STAGES  = 2,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [STAGES-1:0][W-1:0] chain_d, chain_q;

    always_comb begin
        chain_d = {chain_q[STAGES-2:0], d};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= {STAGES{RST_VAL}};
        else        chain_q <= chain_d;
    end

    assign q = chain_q[STAGES-1];

endmodule

// File: rtl/potcmd_edge.sv
module potcmd_edge #(
    parameter int           W       = 1,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] sig,
    output logic [W-1:0] rise,
    output logic [W-1:0] fall
);

    logic [W-1:0] prev_d, prev_q;

    always_comb begin
        prev_d = sig;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= RST_VAL;
        else        prev_q <= prev_d;
    end

    for (genvar i = 0; i < W; i++) begin : g_bit
        assign rise[i] =  sig[i] & ~prev_q[i];
        assign fall[i] = ~sig[i] &  prev_q[i];
    end

endmodule

// File: rtl/potcmd_frame.sv
module potcmd_frame
    import potcmd_pkg::*;
#(
    parameter logic [TYPE_W-1:0] TYPE_CODE = 4'b0101,
    parameter logic [NUM_OP-1:0] WRITE_OPS = 16'h1400,
    parameter logic [NUM_OP-1:0] READ_OPS  = 16'h0A00
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_s,
    input  logic              sck_s,
    input  logic              mosi_s,
    input  logic              hold_s,
    input  logic              sck_rise,
    input  logic [ADDR_W-1:0] strap,
    output logic              cmd_valid,
    output logic              rd_req,
    output logic [OP_W-1:0]   opcode,
    output logic [REG_W-1:0]  regsel,
    output logic              pot,
    output logic [BYTE_W-1:0] data,
    output logic              rd_phase,
    output logic              paused
);

    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);
    localparam int               ZERO_BIT = 1;

    frame_s               q, n;
    logic [BYTE_W-1:0]    byte_v;
    logic                 last_bit;
    logic [OP_W-1:0]      op_v;
    logic                 id_ok;

    always_comb begin
        byte_v   = {q.shreg[BYTE_W-2:0], mosi_s};
        last_bit = (q.bitcnt == LAST_BIT);
        op_v     = byte_v[BYTE_W-1 -: OP_W];
        id_ok    = (byte_v[BYTE_W-1 -: TYPE_W] == TYPE_CODE) &&
                   (byte_v[ADDR_W-1:0] == strap);

        n           = q;
        n.cmd_valid = 1'b0;
        n.rd_req    = 1'b0;

        if (cs_s) begin
            n.st        = ST_IDLE;
            n.seen_high = 1'b1;
            n.paused    = 1'b0;
            n.bitcnt    = '0;
            n.shreg     = '0;
        end else begin
            // pause state only moves while the serial clock is low
            if (!sck_s) n.paused = !hold_s;

            if (q.st == ST_IDLE) begin
                if (q.seen_high) begin
                    n.st     = ST_ID;
                    n.bitcnt = '0;
                end
            end else if (sck_rise && !q.paused && q.st != ST_DONE) begin
                n.shreg  = byte_v;
                n.bitcnt = q.bitcnt + 1'b1;
                if (last_bit) begin
                    unique case (q.st)
                        ST_ID: begin
                            n.st = id_ok ? ST_INSTR : ST_DONE;
                        end
                        ST_INSTR: begin
                            n.opcode = op_v;
                            n.regsel = byte_v[REG_W+1:2];
                            n.pot    = byte_v[0];
                            n.data   = '0;
                            if (byte_v[ZERO_BIT]) begin
                                n.st = ST_DONE;
                            end else if (READ_OPS[op_v]) begin
                                n.rd_req = 1'b1;
                                n.st     = ST_READ;
                            end else if (WRITE_OPS[op_v]) begin
                                n.st = ST_DATA;
                            end else begin
                                n.cmd_valid = 1'b1;
                                n.st        = ST_DONE;
                            end
                        end
                        ST_DATA: begin
                            n.data      = byte_v;
                            n.cmd_valid = 1'b1;
                            n.st        = ST_DONE;
                        end
                        ST_READ: begin
                            n.st = ST_DONE;
                        end
                        default: ;
                    endcase
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q        <= '0;
            q.st     <= ST_IDLE;
        end else begin
            q <= n;
        end
    end

    assign cmd_valid = q.cmd_valid;
    assign rd_req    = q.rd_req;
    assign opcode    = q.opcode;
    assign regsel    = q.regsel;
    assign pot       = q.pot;
    assign data      = q.data;
    assign rd_phase  = (q.st == ST_READ) && !q.paused;
    assign paused    = q.paused;

endmodule

// File: rtl/potcmd_txshift.sv
module potcmd_txshift
    import potcmd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              load,
    input  logic [BYTE_W-1:0] load_data,
    input  logic              shift,
    input  logic              paused,
    output logic              miso,
    output logic              miso_oe
);

    tx_s q, n;

    always_comb begin
        n = q;
        if (clear) begin
            n = '0;
        end else if (load) begin
            n.en    = 1'b1;
            n.shreg = load_data;
        end else if (shift) begin
            n.bit_out = q.shreg[BYTE_W-1];
            n.shreg   = {q.shreg[BYTE_W-2:0], 1'b0};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= n;
    end

    assign miso    = q.bit_out;
    assign miso_oe = q.en && !paused;

endmodule

// File: rtl/potcmd_spi_front.sv
module potcmd_spi_front
    import potcmd_pkg::*;
#(
    parameter int                SYNC_STAGES = 2,
    parameter logic [TYPE_W-1:0] TYPE_CODE   = 4'b0101,
    parameter logic [NUM_OP-1:0] WRITE_OPS   = 16'h1400,
    parameter logic [NUM_OP-1:0] READ_OPS    = 16'h0A00
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              spi_cs_n,
    input  logic              spi_sck,
    input  logic              spi_mosi,
    input  logic              spi_hold_n,
    input  logic [ADDR_W-1:0] strap_addr,
    input  logic [BYTE_W-1:0] rd_data,
    output logic              miso,
    output logic              miso_oe,
    output logic              cmd_valid,
    output logic              rd_req,
    output logic [OP_W-1:0]   cmd_opcode,
    output logic [REG_W-1:0]  cmd_reg,
    output logic              cmd_pot,
    output logic [BYTE_W-1:0] cmd_data
);

    // synchroniser lanes: {cs_n, sck, mosi, hold_n}
    localparam int         N_IN    = 4;
    localparam logic [3:0] IN_RST  = 4'b0001;

    logic [N_IN-1:0] pins_raw, pins_s;
    logic            cs_s, sck_s, mosi_s, hold_s;
    logic            sck_rise, sck_fall;
    logic            rd_phase;
    logic            hold_paused;

    assign pins_raw = {spi_cs_n, spi_sck, spi_mosi, spi_hold_n};

    potcmd_sync #(
        .W       (N_IN),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (IN_RST)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pins_raw),
        .q     (pins_s)
    );

    assign {cs_s, sck_s, mosi_s, hold_s} = pins_s;

    potcmd_edge #(
        .W       (1),
        .RST_VAL (1'b0)
    ) u_sck_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .sig   (sck_s),
        .rise  (sck_rise),
        .fall  (sck_fall)
    );

    potcmd_frame #(
        .TYPE_CODE (TYPE_CODE),
        .WRITE_OPS (WRITE_OPS),
        .READ_OPS  (READ_OPS)
    ) u_frame (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_s      (cs_s),
        .sck_s     (sck_s),
        .mosi_s    (mosi_s),
        .hold_s    (hold_s),
        .sck_rise  (sck_rise),
        .strap     (strap_addr),
        .cmd_valid (cmd_valid),
        .rd_req    (rd_req),
        .opcode    (cmd_opcode),
        .regsel    (cmd_reg),
        .pot       (cmd_pot),
        .data      (cmd_data),
        .rd_phase  (rd_phase),
        .paused    (hold_paused)
    );

    potcmd_txshift u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (cs_s),
        .load      (rd_req),
        .load_data (rd_data),
        .shift     (sck_fall && rd_phase),
        .paused    (hold_paused),
        .miso      (miso),
        .miso_oe   (miso_oe)
    );

endmodule

// File: rtl/potcmd_spi_front_chk.sv
module potcmd_spi_front_chk (
    input logic clk,
    input logic rst_n,
    input logic spi_cs_n,
    input logic cmd_valid,
    input logic rd_req,
    input logic miso_oe,
    input logic paused
);

    // R5: command strobe lasts one cycle
    assert_strobe_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |=> !cmd_valid);

    // R6: the two strobes never coincide
    assert_strobe_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(cmd_valid && rd_req));

    // R7: a read request turns the output driver on in the next cycle
    assert_read_enables_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |=> (miso_oe && !rd_req));

    // R8: chip select held high quiets every output
    assert_deselect_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (spi_cs_n && $past(spi_cs_n) && $past(spi_cs_n, 2) && $past(spi_cs_n, 3))
        |-> (!miso_oe && !cmd_valid && !rd_req));

    // R9: nothing is strobed while the frame is frozen
    assert_pause_no_strobe_R9: assert property (@(posedge clk) disable iff (!rst_n)
        paused |-> (!cmd_valid && !rd_req));

endmodule

bind potcmd_spi_front potcmd_spi_front_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .spi_cs_n  (spi_cs_n),
    .cmd_valid (cmd_valid),
    .rd_req    (rd_req),
    .miso_oe   (miso_oe),
    .paused    (hold_paused)
);

// File: tb/potcmd_spi_front_test.sv
module potcmd_spi_front_test;

    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       spi_cs_n = 1'b0;
    logic       spi_sck = 1'b0;
    logic       spi_mosi = 1'b0;
    logic       spi_hold_n = 1'b1;
    logic [3:0] strap_addr = 4'h6;
    logic [7:0] rd_data = 8'h00;
    logic       miso, miso_oe, cmd_valid, rd_req, cmd_pot;
    logic [3:0] cmd_opcode;
    logic [1:0] cmd_reg;
    logic [7:0] cmd_data;

    always #(CLK_PERIOD/2) clk = ~clk;

    potcmd_spi_front uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .spi_cs_n   (spi_cs_n),
        .spi_sck    (spi_sck),
        .spi_mosi   (spi_mosi),
        .spi_hold_n (spi_hold_n),
        .strap_addr (strap_addr),
        .rd_data    (rd_data),
        .miso       (miso),
        .miso_oe    (miso_oe),
        .cmd_valid  (cmd_valid),
        .rd_req     (rd_req),
        .cmd_opcode (cmd_opcode),
        .cmd_reg    (cmd_reg),
        .cmd_pot    (cmd_pot),
        .cmd_data   (cmd_data)
    );

    int          n_checks = 0;
    int          n_fail   = 0;
    int          strobes  = 0;
    bit          finished = 0;
    string       cur_tag  = "R2";
    logic [15:0] exp_q[$];
    string       tag_q[$];

    task automatic chk(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] mk(input bit rd, input logic [3:0] op, input logic [1:0] rg,
                                       input bit p, input logic [7:0] d);
        return {rd, op, rg, p, d};
    endfunction

    task automatic expect_cmd(input logic [15:0] item, input string tag);
        exp_q.push_back(item);
        tag_q.push_back(tag);
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && (cmd_valid || rd_req)) begin
            logic [15:0] act;
            act = {rd_req, cmd_opcode, cmd_reg, cmd_pot, cmd_data};
            strobes++;
            if (exp_q.size() == 0) begin
                chk(1'b0, cur_tag, act, 16'h0000);
            end else begin
                logic [15:0] e;
                string       t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                chk(act == e, t, act, e);
            end
        end
    end

    task automatic wait_clks(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic do_pause(input bit chk_oe);
        spi_hold_n = 1'b0;
        wait_clks(6);
        if (chk_oe) chk(miso_oe == 1'b0, "R9", {15'd0, miso_oe}, 16'd0);
        // ignored clock pulses with garbage data
        for (int k = 0; k < 2; k++) begin
            spi_mosi = ~spi_mosi;
            spi_sck  = 1'b1;
            wait_clks(HALF);
            spi_sck  = 1'b0;
            wait_clks(HALF);
        end
        spi_hold_n = 1'b1;
        wait_clks(6);
        if (chk_oe) chk(miso_oe == 1'b1, "R9", {15'd0, miso_oe}, 16'd1);
    endtask

    task automatic xfer(input logic [7:0] tx, output logic [7:0] rx,
                        input int nbits = 8, input int pause_at = -1, input bit chk_oe = 0);
        rx = 8'h00;
        for (int i = 7; i >= 8 - nbits; i--) begin
            if (i == pause_at) do_pause(chk_oe);
            spi_mosi = tx[i];
            wait_clks(HALF);
            rx[i]    = miso;
            spi_sck  = 1'b1;
            wait_clks(HALF);
            spi_sck  = 1'b0;
        end
    endtask

    task automatic cs_begin();
        spi_cs_n = 1'b0;
        wait_clks(HALF);
    endtask

    task automatic cs_end();
        wait_clks(HALF);
        spi_cs_n = 1'b1;
        wait_clks(10);
    endtask

    function automatic logic [7:0] instr(input logic [3:0] op, input logic [1:0] rg, input bit p);
        return {op, rg, 1'b0, p};
    endfunction

    initial begin
        logic [7:0] rx;
        int         s0;

        // R1: reset state
        wait_clks(3);
        chk(!miso_oe && !cmd_valid && !rd_req, "R1", {13'd0, miso_oe, cmd_valid, rd_req}, 16'd0);
        rst_n = 1'b1;
        wait_clks(2);
        chk(!miso_oe && !cmd_valid && !rd_req, "R1", {13'd0, miso_oe, cmd_valid, rd_req}, 16'd0);

        // R2: chip select low since reset, full write frame ignored
        cur_tag = "R2";
        s0 = strobes;
        xfer({4'b0101, strap_addr}, rx);
        xfer(instr(4'hA, 2'd1, 1'b0), rx);
        xfer(8'h77, rx);
        wait_clks(10);
        chk(strobes == s0, "R2", 16'(strobes), 16'(s0));
        chk(miso_oe == 1'b0, "R2", {15'd0, miso_oe}, 16'd0);
        cs_end();

        // R5: write opcode with data byte
        cur_tag = "R5";
        cs_begin();
        xfer({4'b0101, strap_addr}, rx);
        expect_cmd(mk(0, 4'hA, 2'd2, 1'b1, 8'h3C), "R5");
        xfer(instr(4'hA, 2'd2, 1'b1), rx);
        xfer(8'h3C, rx);
        wait_clks(10);
        chk(exp_q.size() == 0, "R5", 16'(exp_q.size()), 16'd0);
        cs_end();

        // R5 + R3: second write opcode under another strap value
        strap_addr = 4'h9;
        wait_clks(4);
        cs_begin();
        xfer({4'b0101, 4'h9}, rx);
        expect_cmd(mk(0, 4'hC, 2'd1, 1'b0, 8'hC3), "R5");
        xfer(instr(4'hC, 2'd1, 1'b0), rx);
        xfer(8'hC3, rx);
        wait_clks(10);
        chk(exp_q.size() == 0, "R3", 16'(exp_q.size()), 16'd0);
        cs_end();

        // R6: opcode with no data byte
        cur_tag = "R6";
        cs_begin();
        xfer({4'b0101, strap_addr}, rx);
        expect_cmd(mk(0, 4'h2, 2'd3, 1'b1, 8'h00), "R6");
        xfer(instr(4'h2, 2'd3, 1'b1), rx);
        wait_clks(10);
        chk(exp_q.size() == 0, "R6", 16'(exp_q.size()), 16'd0);
        cs_end();

        // R7: read opcodes
        cur_tag = "R7";
        rd_data = 8'hA5;
        cs_begin();
        xfer({4'b0101, strap_addr}, rx);
        expect_cmd(mk(1, 4'h9, 2'd1, 1'b0, 8'h00), "R7");
        xfer(instr(4'h9, 2'd1, 1'b0), rx);
        chk(miso_oe == 1'b1, "R7", {15'd0, miso_oe}, 16'd1);
        xfer(8'h00, rx);
        chk(rx == 8'hA5, "R7", {8'd0, rx}, 16'h00A5);
        cs_end();
        chk(miso_oe == 1'b0, "R8", {15'd0, miso_oe}, 16'd0);

        rd_data = 8'h5A;
        cs_begin();
        xfer({4'b0101, strap_addr}, rx);
        expect_cmd(mk(1, 4'hB, 2'd0, 1'b1, 8'h00), "R7");
        xfer(instr(4'hB, 2'd0, 1'b1), rx);
        xfer(8'h00, rx);
        chk(rx == 8'h5A, "R7", {8'd0, rx}, 16'h005A);
        cs_end();

        // R3: wrong type code, then wrong address
        cur_tag = "R3";
        s0 = strobes;
        cs_begin();
        xfer({4'b0110, strap_addr}, rx);
        xfer(instr(4'h9, 2'd0, 1'b0), rx);
        xfer(8'h00, rx);
        chk(miso_oe == 1'b0, "R3", {15'd0, miso_oe}, 16'd0);
        cs_end();
        cs_begin();
        xfer({4'b0101, strap_addr ^ 4'h1}, rx);
        xfer(instr(4'h2, 2'd0, 1'b0), rx);
        wait_clks(10);
        cs_end();
        chk(strobes == s0, "R3", 16'(strobes), 16'(s0));

        // R4: must-be-zero bit set
        cur_tag = "R4";
        s0 = strobes;
        cs_begin();
        xfer({4'b0101, strap_addr}, rx);
        xfer({4'hA, 2'd0, 1'b1, 1'b0}, rx);
        xfer(8'h11, rx);
        wait_clks(10);
        cs_end();
        chk(strobes == s0, "R4", 16'(strobes), 16'(s0));

        // R8: aborted frame leaves no residue
        cur_tag = "R8";
        cs_begin();
        xfer({4'b0101, strap_addr}, rx);
        xfer(8'hFF, rx, 5);
        cs_end();
        cs_begin();
        xfer({4'b0101, strap_addr}, rx);
        expect_cmd(mk(0, 4'hA, 2'd3, 1'b0, 8'h96), "R8");
        xfer(instr(4'hA, 2'd3, 1'b0), rx);
        xfer(8'h96, rx);
        wait_clks(10);
        chk(exp_q.size() == 0, "R8", 16'(exp_q.size()), 16'd0);
        cs_end();

        // R9: pause inside a write data byte and inside a read byte
        cur_tag = "R9";
        cs_begin();
        xfer({4'b0101, strap_addr}, rx);
        expect_cmd(mk(0, 4'hC, 2'd2, 1'b0, 8'h4B), "R9");
        xfer(instr(4'hC, 2'd2, 1'b0), rx);
        xfer(8'h4B, rx, 8, 3);
        wait_clks(10);
        chk(exp_q.size() == 0, "R9", 16'(exp_q.size()), 16'd0);
        cs_end();

        rd_data = 8'hD2;
        cs_begin();
        xfer({4'b0101, strap_addr}, rx);
        expect_cmd(mk(1, 4'h9, 2'd2, 1'b1, 8'h00), "R9");
        xfer(instr(4'h9, 2'd2, 1'b1), rx);
        xfer(8'h00, rx, 8, 4, 1'b1);
        chk(rx == 8'hD2, "R9", {8'd0, rx}, 16'h00D2);
        cs_end();

        // R10: trailing bytes after a completed write
        cur_tag = "R10";
        s0 = strobes;
        cs_begin();
        xfer({4'b0101, strap_addr}, rx);
        expect_cmd(mk(0, 4'hA, 2'd0, 1'b1, 8'hE1), "R10");
        xfer(instr(4'hA, 2'd0, 1'b1), rx);
        xfer(8'hE1, rx);
        xfer(8'h2C, rx);
        xfer(instr(4'h2, 2'd0, 1'b0), rx);
        wait_clks(10);
        cs_end();
        chk(strobes == s0 + 1, "R10", 16'(strobes), 16'(s0 + 1));
        chk(exp_q.size() == 0, "R10", 16'(exp_q.size()), 16'd0);

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=%h expected=%h", 16'd0, 16'd1);
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

endmodule